// File: doc/BRIEF.md
# Two-Manager Write Path Merger

This block joins the write-side channels of two bus managers onto a single subordinate port that follows AXI4 write rules. A weighted round-robin arbiter chooses which manager's address request goes forward. Every accepted request writes its manager index into a small ring of owner tags. The data channel is then steered strictly from the oldest unfinished entry, so write bursts leave the block in the order their addresses were accepted and never interleave. Write responses go back to the owners in the same order.

The ring has two read positions. One is the data head, which advances on the handshake of a final beat. The other is the response head, which advances on a response handshake. A slot becomes free only when its response has completed, so the ring depth limits the number of writes that can be outstanding. No per-ID lookup is used. A manager whose data is slow therefore holds the data path until its burst ends.

Top module: `wr_merge2`

## Requirements
- R1: When both managers request continuously from reset, grants repeat in the pattern WGT0 grants to manager 0 followed by WGT1 grants to manager 1, and the first grant goes to manager 0 (default weights 3 and 1).
- R2: A manager that requests alone is granted in every cycle in which the subordinate is ready and fewer than DEPTH writes are outstanding. A manager never receives more than its weight in consecutive grants while the other manager is waiting.
- R3: At most DEPTH writes are outstanding (address accepted, response not yet completed). At that count AWREADY is low to both managers, and a slot is freed only by a response handshake, not by the end of the data.
- R4: Write data reaches the subordinate in address acceptance order. Each burst passes contiguously up to its last beat, with data and last flag unchanged, and no beat is forwarded for an address that has not been accepted.
- R5: WREADY is low to any manager that does not own the oldest unfinished burst, even when that manager holds valid data and the owner is slow.
- R6: Write responses are routed in grant order. BVALID reaches only the owning manager, the ID and response code pass unchanged, and the subordinate sees BREADY from that owner.
- R7: An address request offered to the subordinate and not yet accepted keeps its ID, address and length until it is accepted, even if the other manager raises its valid in the meantime. The accepted payload equals the granted manager's request.
- R8: Reset is synchronous and active low. It empties the ring, returns the arbiter to manager 0 with no credit used, and afterwards forwards no data belonging to writes granted before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m0_awvalid | input | 1 | Manager 0 address valid |
| m0_awready | output | 1 | Manager 0 address ready |
| m0_awid | input | ID_W | Manager 0 write ID |
| m0_awaddr | input | ADDR_W | Manager 0 write address |
| m0_awlen | input | LEN_W | Manager 0 beats minus one |
| m0_wvalid | input | 1 | Manager 0 data valid |
| m0_wready | output | 1 | Manager 0 data ready |
| m0_wdata | input | DATA_W | Manager 0 write data |
| m0_wlast | input | 1 | Manager 0 final beat flag |
| m0_bvalid | output | 1 | Manager 0 response valid |
| m0_bready | input | 1 | Manager 0 response ready |
| m0_bid | output | ID_W | Manager 0 response ID |
| m0_bresp | output | 2 | Manager 0 response code |
| m1_awvalid | input | 1 | Manager 1 address valid |
| m1_awready | output | 1 | Manager 1 address ready |
| m1_awid | input | ID_W | Manager 1 write ID |
| m1_awaddr | input | ADDR_W | Manager 1 write address |
| m1_awlen | input | LEN_W | Manager 1 beats minus one |
| m1_wvalid | input | 1 | Manager 1 data valid |
| m1_wready | output | 1 | Manager 1 data ready |
| m1_wdata | input | DATA_W | Manager 1 write data |
| m1_wlast | input | 1 | Manager 1 final beat flag |
| m1_bvalid | output | 1 | Manager 1 response valid |
| m1_bready | input | 1 | Manager 1 response ready |
| m1_bid | output | ID_W | Manager 1 response ID |
| m1_bresp | output | 2 | Manager 1 response code |
| s_awvalid | output | 1 | Subordinate address valid |
| s_awready | input | 1 | Subordinate address ready |
| s_awid | output | ID_W | Subordinate write ID |
| s_awaddr | output | ADDR_W | Subordinate write address |
| s_awlen | output | LEN_W | Subordinate beats minus one |
| s_wvalid | output | 1 | Subordinate data valid |
| s_wready | input | 1 | Subordinate data ready |
| s_wdata | output | DATA_W | Subordinate write data |
| s_wlast | output | 1 | Subordinate final beat flag |
| s_bvalid | input | 1 | Subordinate response valid |
| s_bready | output | 1 | Subordinate response ready |
| s_bid | input | ID_W | Subordinate response ID |
| s_bresp | input | 2 | Subordinate response code |

## Verification
Three things can fall in one clock edge: a new address push, the pop of a final data beat and the pop of a response. The ring then has to count all three correctly at its full boundary. The bench provokes this by letting both managers request continuously while the subordinate throttles data ready on a 5-cycle pattern and response valid on a 2-cycle pattern, with manager 1 offering data only every third cycle. Under this load it compares every granted address, data beat and response against an order log it keeps itself. In a second pass it holds data and responses back, and it checks that the block stops at DEPTH grants and does not resume when the data drains, only once the responses complete.

// File: rtl/wr_merge2.sv
module wr_merge2 #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 4,
  parameter int WGT0   = 3,
  parameter int WGT1   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m0_awvalid,
  output logic              m0_awready,
  input  logic [ID_W-1:0]   m0_awid,
  input  logic [ADDR_W-1:0] m0_awaddr,
  input  logic [LEN_W-1:0]  m0_awlen,
  input  logic              m0_wvalid,
  output logic              m0_wready,
  input  logic [DATA_W-1:0] m0_wdata,
  input  logic              m0_wlast,
  output logic              m0_bvalid,
  input  logic              m0_bready,
  output logic [ID_W-1:0]   m0_bid,
  output logic [1:0]        m0_bresp,
  input  logic              m1_awvalid,
  output logic              m1_awready,
  input  logic [ID_W-1:0]   m1_awid,
  input  logic [ADDR_W-1:0] m1_awaddr,
  input  logic [LEN_W-1:0]  m1_awlen,
  input  logic              m1_wvalid,
  output logic              m1_wready,
  input  logic [DATA_W-1:0] m1_wdata,
  input  logic              m1_wlast,
  output logic              m1_bvalid,
  input  logic              m1_bready,
  output logic [ID_W-1:0]   m1_bid,
  output logic [1:0]        m1_bresp,
  output logic              s_awvalid,
  input  logic              s_awready,
  output logic [ID_W-1:0]   s_awid,
  output logic [ADDR_W-1:0] s_awaddr,
  output logic [LEN_W-1:0]  s_awlen,
  output logic              s_wvalid,
  input  logic              s_wready,
  output logic [DATA_W-1:0] s_wdata,
  output logic              s_wlast,
  input  logic              s_bvalid,
  output logic              s_bready,
  input  logic [ID_W-1:0]   s_bid,
  input  logic [1:0]        s_bresp
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int WMAX = (WGT0 > WGT1) ? WGT0 : WGT1;
  localparam int KW   = $clog2(WMAX + 1) + 1;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [1:0]       awv;
  logic             ptr, hold, hold_sel;
  logic [KW-1:0]    used;
  logic [DEPTH-1:0] owner;
  logic [PW-1:0]    wr_p, wh_p, bh_p;
  logic [CW-1:0]    w_cnt, b_cnt;

  assign awv = {m1_awvalid, m0_awvalid};

  // address arbitration: a pending offer is frozen until accepted
  wire full = (b_cnt == CW'(DEPTH));
  wire pick = hold ? hold_sel : (awv[ptr] ? ptr : ~ptr);
  wire aw_hs = s_awvalid & s_awready;
  wire [KW-1:0] wgt_pick = pick ? KW'(WGT1) : KW'(WGT0);
  wire [KW-1:0] used_nx  = (pick == ptr) ? used + KW'(1) : KW'(1);

  assign s_awvalid  = awv[pick] & ~full;
  assign s_awid     = pick ? m1_awid   : m0_awid;
  assign s_awaddr   = pick ? m1_awaddr : m0_awaddr;
  assign s_awlen    = pick ? m1_awlen  : m0_awlen;
  assign m0_awready = aw_hs & ~pick;
  assign m1_awready = aw_hs & pick;

  // data steering from the oldest unfinished entry
  wire w_any  = (w_cnt != '0);
  wire w_own  = owner[wh_p];
  wire w_done = s_wvalid & s_wready & s_wlast;

  assign s_wvalid  = w_any & (w_own ? m1_wvalid : m0_wvalid);
  assign s_wdata   = w_own ? m1_wdata : m0_wdata;
  assign s_wlast   = w_own ? m1_wlast : m0_wlast;
  assign m0_wready = w_any & ~w_own & s_wready;
  assign m1_wready = w_any & w_own & s_wready;

  // response return in grant order
  wire b_any  = (b_cnt != '0);
  wire b_own  = owner[bh_p];
  wire b_done = s_bvalid & s_bready;

  assign m0_bvalid = s_bvalid & b_any & ~b_own;
  assign m1_bvalid = s_bvalid & b_any & b_own;
  assign m0_bid    = s_bid;
  assign m1_bid    = s_bid;
  assign m0_bresp  = s_bresp;
  assign m1_bresp  = s_bresp;
  assign s_bready  = b_any & (b_own ? m1_bready : m0_bready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= 1'b0;
      used     <= '0;
      hold     <= 1'b0;
      hold_sel <= 1'b0;
      owner    <= '0;
      wr_p     <= '0;
      wh_p     <= '0;
      bh_p     <= '0;
      w_cnt    <= '0;
      b_cnt    <= '0;
    end else begin
      hold     <= s_awvalid & ~s_awready;
      hold_sel <= pick;
      if (aw_hs) begin
        owner[wr_p] <= pick;
        wr_p        <= step(wr_p);
        if (used_nx >= wgt_pick) begin
          ptr  <= ~pick;
          used <= '0;
        end else begin
          ptr  <= pick;
          used <= used_nx;
        end
      end
      if (w_done) wh_p <= step(wh_p);
      if (b_done) bh_p <= step(bh_p);
      w_cnt <= w_cnt + CW'(aw_hs) - CW'(w_done);
      b_cnt <= b_cnt + CW'(aw_hs) - CW'(b_done);
    end
  end

  // streak of contested grants, kept only for the fairness check
  logic          stk_mgr;
  logic [KW-1:0] stk_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk_mgr <= 1'b0;
      stk_len <= '0;
    end else if (aw_hs) begin
      if (!awv[~pick]) stk_len <= '0;
      else if (stk_mgr == pick && stk_len != '0) stk_len <= stk_len + KW'(1);
      else begin
        stk_mgr <= pick;
        stk_len <= KW'(1);
      end
    end
  end

  p_fair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_hs && awv[~pick] && stk_mgr == pick && stk_len != '0) |-> (stk_len < wgt_pick));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cnt <= CW'(DEPTH)) && (w_cnt <= b_cnt));

  p_w_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wvalid && !s_wready) |=> (s_wvalid && $stable(s_wdata) && $stable(s_wlast)));

  p_one_wready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m1_wready, m0_wready}));

  p_one_bvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m1_bvalid, m0_bvalid}));

  p_aw_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awvalid && !s_awready) |=> (s_awvalid && $stable(s_awid) && $stable(s_awaddr) && $stable(s_awlen)));
endmodule

// File: tb/wr_merge2_test.sv
module wr_merge2_test;
  localparam int PERIOD = 10;
  localparam int QD = 4;
  localparam int WA = 3;
  localparam int WB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [1:0]  awv, awr, wvld, wr, bv_o;
  logic [3:0]  awid [2];
  logic [31:0] awaddr [2];
  logic [7:0]  awlen [2];
  logic [31:0] wdata [2];
  logic [1:0]  wlast;
  logic [3:0]  bid_o [2];
  logic [1:0]  bresp_o [2];
  logic        s_awvalid, s_awready, s_wvalid, s_wready, s_wlast, s_bvalid, s_bready;
  logic [3:0]  s_awid, s_bid;
  logic [31:0] s_awaddr, s_wdata;
  logic [7:0]  s_awlen;
  logic [1:0]  s_bresp;

  wr_merge2 #(.ID_W(4), .ADDR_W(32), .DATA_W(32), .LEN_W(8), .DEPTH(QD), .WGT0(WA), .WGT1(WB)) uut (
    .clk(clk), .rst_n(rst_n),
    .m0_awvalid(awv[0]), .m0_awready(awr[0]), .m0_awid(awid[0]), .m0_awaddr(awaddr[0]), .m0_awlen(awlen[0]),
    .m0_wvalid(wvld[0]), .m0_wready(wr[0]), .m0_wdata(wdata[0]), .m0_wlast(wlast[0]),
    .m0_bvalid(bv_o[0]), .m0_bready(1'b1), .m0_bid(bid_o[0]), .m0_bresp(bresp_o[0]),
    .m1_awvalid(awv[1]), .m1_awready(awr[1]), .m1_awid(awid[1]), .m1_awaddr(awaddr[1]), .m1_awlen(awlen[1]),
    .m1_wvalid(wvld[1]), .m1_wready(wr[1]), .m1_wdata(wdata[1]), .m1_wlast(wlast[1]),
    .m1_bvalid(bv_o[1]), .m1_bready(1'b1), .m1_bid(bid_o[1]), .m1_bresp(bresp_o[1]),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp)
  );

  int checks = 0, fails = 0, cyc_n = 0;
  int lim [2], aw_seq [2], w_seq [2], w_beat [2], b_seq [2];
  bit wv [2];
  int log_m [256], log_s [256];
  int n_log = 0, w_idx = 0, wb = 0, b_idx = 0;
  bit s_awr = 0, s_wr_en = 0, b_en = 0, bvh = 0, chk_pat = 0;

  function automatic int blen(int m, int s);
    return ((s + m) % 3) + 1;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic observe();
    int outst, em, es, exp_m;
    logic [31:0] ed;
    bit el, ok;
    outst = n_log - b_idx;
    if (outst == QD && awv != 2'b00) check(awr == 2'b00, "R3 ready at full", awr, 0);
    if (s_awr && outst < QD && (awv == 2'b01 || awv == 2'b10))
      check(awr == awv, "R2 lone requester", awr, awv);
    for (int m = 0; m < 2; m++)
      if (wvld[m] && (w_idx >= n_log || log_m[w_idx] != m))
        check(wr[m] == 1'b0, "R5 non-head wready", wr[m], 0);
    if (s_wvalid && s_wready) begin
      if (w_idx >= n_log) check(0, "R4 beat without grant", s_wdata, 0);
      else begin
        em = log_m[w_idx];
        es = log_s[w_idx];
        ed = 32'((em << 16) | ((es & 255) << 8) | wb);
        el = (wb == blen(em, es) - 1);
        check(s_wdata == ed && s_wlast == el, "R4 beat order", s_wdata, ed);
        if (el) begin w_idx++; wb = 0; end
        else wb++;
      end
    end
    for (int m = 0; m < 2; m++)
      if (bv_o[m]) begin
        ok = (b_idx < w_idx) && (log_m[b_idx] == m) && (bid_o[m] == 4'(m)) && (bresp_o[m] == 2'(b_seq[m]));
        check(ok, "R6 response route", bresp_o[m], b_seq[m] & 3);
        b_seq[m]++;
      end
    if (s_bvalid) begin
      check(s_bready, "R6 bready from owner", s_bready, 1);
      if (s_bready) begin b_idx++; bvh = 0; end
    end
    for (int m = 0; m < 2; m++)
      if (wvld[m] && wr[m]) begin
        wv[m] = 0;
        if (wlast[m]) begin w_seq[m]++; w_beat[m] = 0; end
        else w_beat[m]++;
      end
    for (int m = 0; m < 2; m++)
      if (awv[m] && awr[m]) begin
        check(s_awaddr == awaddr[m] && s_awid == awid[m] && s_awlen == awlen[m], "R7 payload", s_awaddr, awaddr[m]);
        if (chk_pat) begin
          exp_m = (n_log < 16) ? (((n_log % (WA + WB)) < WA) ? 0 : 1) : 1;
          check(m == exp_m, "R1 grant pattern", m, exp_m);
        end
        log_m[n_log] = m;
        log_s[n_log] = aw_seq[m];
        n_log++;
        aw_seq[m]++;
      end
  endtask

  initial begin : engine
    awv = '0; wvld = '0; wlast = '0;
    s_awready = 0; s_wready = 0; s_bvalid = 0; s_bid = '0; s_bresp = '0;
    forever begin
      @(negedge clk);
      cyc_n++;
      for (int m = 0; m < 2; m++) begin
        awv[m]    = (aw_seq[m] < lim[m]);
        awaddr[m] = 32'((m << 12) | aw_seq[m]);
        awid[m]   = 4'(m);
        awlen[m]  = 8'(blen(m, aw_seq[m]) - 1);
        if (!wv[m]) wv[m] = (w_seq[m] < aw_seq[m]) && (m == 0 || cyc_n % 3 == 0);
        wvld[m]   = wv[m];
        wdata[m]  = 32'((m << 16) | ((w_seq[m] & 255) << 8) | w_beat[m]);
        wlast[m]  = (w_beat[m] == blen(m, w_seq[m]) - 1);
      end
      s_awready = s_awr;
      s_wready  = s_wr_en && (cyc_n % 5 != 4);
      if (!bvh) bvh = b_en && (b_idx < w_idx) && (cyc_n % 2 == 0);
      s_bvalid = bvh;
      s_bid    = 4'(log_m[b_idx]);
      s_bresp  = 2'(log_s[b_idx]);
      #(PERIOD/4);
      observe();
    end
  end

  task automatic do_reset(bit keep);
    rst_n = 0;
    n_log = 0; w_idx = 0; wb = 0; b_idx = 0; bvh = 0;
    s_awr = 0; s_wr_en = 0; b_en = 0; chk_pat = 0;
    if (!keep)
      for (int m = 0; m < 2; m++) begin
        lim[m] = 0; aw_seq[m] = 0; w_seq[m] = 0; w_beat[m] = 0; b_seq[m] = 0; wv[m] = 0;
      end
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (!(aw_seq[0] == lim[0] && aw_seq[1] == lim[1] && w_seq[0] == aw_seq[0] &&
             w_seq[1] == aw_seq[1] && w_idx == n_log && b_idx == n_log) && n < 3000) begin
      cyc(1);
      n++;
    end
    check(n < 3000, "drain watchdog", n, 3000);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    for (int m = 0; m < 2; m++) begin
      lim[m] = 0; aw_seq[m] = 0; w_seq[m] = 0; w_beat[m] = 0; b_seq[m] = 0; wv[m] = 0;
    end
    do_reset(0);
    check(s_awvalid == 0, "R8 idle awvalid", s_awvalid, 0);
    check(s_wvalid == 0, "R8 idle wvalid", s_wvalid, 0);
    check(bv_o == 2'b00 && awr == 2'b00 && wr == 2'b00, "R8 idle readies", {bv_o, awr, wr}, 0);

    // R7: frozen offer while the other manager arrives late
    lim[1] = 1;
    cyc(3);
    check(s_awvalid == 1 && s_awid == 4'd1, "R7 offer from m1", s_awid, 1);
    lim[0] = 1;
    cyc(2);
    check(s_awid == 4'd1 && s_awaddr == 32'h1000, "R7 offer frozen", s_awaddr, 32'h1000);
    s_awr = 1; s_wr_en = 1; b_en = 1;
    wait_idle();
    check(n_log == 2 && log_m[0] == 1 && log_m[1] == 0, "R7 accept order", log_m[0], 1);

    // R1, R2, R4, R5, R6: both busy, throttled data and responses, slow m1 data
    do_reset(0);
    chk_pat = 1; s_awr = 1; s_wr_en = 1; b_en = 1;
    lim[0] = 12; lim[1] = 12;
    wait_idle();
    check(n_log == 24 && b_seq[0] == 12 && b_seq[1] == 12, "R6 all responses", b_idx, 24);

    // R3: slots free only on response
    do_reset(0);
    s_awr = 1;
    lim[0] = 6; lim[1] = 6;
    cyc(20);
    check(n_log == QD, "R3 stop at depth", n_log, QD);
    s_wr_en = 1;
    cyc(40);
    check(n_log == QD, "R3 data drain frees nothing", n_log, QD);
    check(w_idx == QD, "R4 held bursts drained", w_idx, QD);
    b_en = 1;
    wait_idle();
    check(n_log == 12 && b_idx == 12, "R3 resumes after responses", b_idx, 12);

    // R8: reset drops granted writes
    do_reset(0);
    s_awr = 1;
    lim[0] = 2;
    cyc(10);
    check(n_log == 2, "R8 two grants before reset", n_log, 2);
    lim[0] = aw_seq[0];
    do_reset(1);
    cyc(4);
    check(wvld[0] == 1 && s_wvalid == 0 && wr == 2'b00, "R8 no stale data forwarded", s_wvalid, 0);
    check(s_awvalid == 0, "R8 no stale address", s_awvalid, 0);
    do_reset(0);
    cyc(2);
    finish_run();
  end
endmodule